// File: doc/BRIEF.md
# Byte-Stream Packet Error Code Guard

This block runs next to a two-wire serial byte engine and keeps a running CRC-8 over every bit the engine shifts. That includes the address byte together with its read/write bit. The shift register reports each bit with a strobe and marks the close of each byte with a separate strobe. The CRC register follows the stream one bit at a time, most significant bit first, using the generator 0x07 and a starting value of zero. It runs only while the enable input is high.

A PEC request is armed in one of two ways: by software, or by an end-of-transfer hint from a DMA controller while DMA handling is on. When the block is transmitting, the armed request makes it capture the running CRC at the close of the final data byte. It then tells the transmit path to send that value as the next byte. When the block is receiving, the armed request marks the next byte to close as the PEC. That byte is folded into the CRC like any other. A correct PEC leaves a residue of zero, so a non-zero residue means a mismatch. The block uses the residue to decide the ACK or NACK for that byte and to set a sticky error flag. A master receiver sends NACK after a software-armed PEC or a final DMA PEC whatever the result. An intermediate DMA PEC (not final) is acknowledged when it matches, and the block pulses a DMA request after it. If arbitration is lost, the block marks the CRC as untrustworthy until the next START or until the block is disabled.

Top module: `pec_guard`

## Requirements
- R1: Each bit strobe folds its bit into the CRC, most significant bit first. The generator is 0x07 (x^8+x^2+x+1), the start value is 0x00, and there is no final inversion. The new value appears on `crc_value` one clock after the strobe. The nine ASCII bytes "123456789" give 0xF4.
- R2: While `pec_en` is low, `crc_value` is 0x00 from the next clock on. Bit strobes have no effect, and any armed request or pending PEC slot is dropped.
- R3: A `start_det` pulse while enabled clears `crc_value` to 0x00 and clears `crc_bad` on the next clock.
- R4: On transmit, if a request was armed in a cycle before the `byte_end` of the last data byte, three things happen from the next clock. `pec_value` holds the CRC as it stood at that `byte_end`. `tx_pec_ins` is high and stays high until the `byte_end` of the PEC byte. `pec_value` does not change while the slot is open. After that closing `byte_end`, `crc_value` is 0x00.
- R5: A request raised in the same cycle as a `byte_end` does not apply to that byte. It applies to the next byte that closes.
- R6: On receive, the first `byte_end` after arming marks the PEC byte. In that cycle `rx_nack` is high if the CRC residue after the PEC bits is non-zero. The CRC is then cleared.
- R7: For a master receiver (`is_master` high), `rx_nack` is forced high on a PEC byte armed by software, or by DMA with `dma_last` high. A DMA-armed PEC with `dma_last` low is acknowledged when the residue is zero.
- R8: A PEC mismatch sets `pec_err` on the next clock. The flag stays set until `err_clr`. A mismatch in the same cycle as `err_clr` wins.
- R9: `dma_eot` arms a PEC request only while `dma_en` is high. With `dma_en` low it is ignored.
- R10: After a received PEC byte that was armed by DMA, `dma_pec_req` is high for exactly one clock, the one following its `byte_end`.
- R11: `arb_lost` sets `crc_bad` on the next clock. It stays set until a `start_det` or until `pec_en` goes low.
- R12: `rx_nack` is low in every cycle except a receive `byte_end` of an armed PEC byte. Ordinary data bytes never get a NACK from this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pec_en | input | 1 | PEC calculation enable |
| start_det | input | 1 | START condition seen on the bus (pulse) |
| arb_lost | input | 1 | Arbitration lost (pulse) |
| bit_vld | input | 1 | A bit has been shifted (pulse) |
| bit_val | input | 1 | Value of that bit |
| byte_end | input | 1 | The current byte has closed (pulse, never with `bit_vld`) |
| is_tx | input | 1 | 1 when the engine transmits, 0 when it receives |
| is_master | input | 1 | Engine is bus master |
| sw_pec_req | input | 1 | Software PEC request (pulse) |
| dma_en | input | 1 | DMA handling on |
| dma_eot | input | 1 | DMA end-of-transfer hint (pulse) |
| dma_last | input | 1 | The DMA end-of-transfer is the final one |
| err_clr | input | 1 | Clears the sticky mismatch flag |
| crc_value | output | W | Running CRC |
| pec_value | output | W | PEC byte to transmit |
| tx_pec_ins | output | 1 | Next transmitted byte must be `pec_value` |
| rx_nack | output | 1 | NACK decision, valid in a receive `byte_end` cycle |
| pec_err | output | 1 | Sticky PEC mismatch flag |
| crc_bad | output | 1 | CRC corrupted by arbitration loss |
| dma_pec_req | output | 1 | DMA request after a DMA-armed received PEC |

## Verification
The bench builds the block with its defaults: an 8-bit CRC, generator 0x07, and a two-stage reset synchroniser. These values make the public check value for "123456789" directly comparable, and they let the bench build a matching PEC for any message so that the zero-residue path can be reached. With a width of eight, one ordinary address byte plus a data byte exercises every feedback tap. The bench flips a single bit of a correct PEC to reach the mismatch path, and it pairs each arming source with both master and slave receive to cover every NACK combination.

// File: rtl/pec_pkg.sv
package pec_pkg;
  localparam int unsigned PEC_W_DEF = 8;
  localparam logic [7:0]  PEC_POLY_DEF = 8'h07;

  // where the currently armed request came from
  typedef struct packed {
    logic from_dma;   // armed by a DMA end-of-transfer hint
    logic final_xfer; // request is final (software requests always are)
  } pec_src_t;
endpackage

// File: rtl/pec_rst_sync.sv
module pec_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] sync_q;
  logic [LAST:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = 1'b1;
    end else begin : g_many
      assign sync_d = {sync_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[LAST];
endmodule

// File: rtl/pec_crc_serial.sv
module pec_crc_serial #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] POLY = 8'h07
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic [W-1:0] crc_q;
  logic [W-1:0] crc_d;
  logic [W-1:0] stepped;
  logic         fb;

  assign fb = crc_q[W-1] ^ din;

  // one serial step: shift left, xor generator taps when feedback is set
  generate
    for (genvar i = 0; i < W; i++) begin : g_tap
      if (i == 0) begin : g_lsb
        assign stepped[i] = fb & POLY[i];
      end else begin : g_up
        assign stepped[i] = crc_q[i-1] ^ (fb & POLY[i]);
      end
    end
  endgenerate

  always_comb begin
    crc_d = crc_q;
    if (clr)        crc_d = '0;
    else if (shift) crc_d = stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/pec_seq.sv
module pec_seq
  import pec_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pec_en,
  input  logic         start_det,
  input  logic         arb_lost,
  input  logic         byte_end,
  input  logic         is_tx,
  input  logic         is_master,
  input  logic         sw_pec_req,
  input  logic         dma_en,
  input  logic         dma_eot,
  input  logic         dma_last,
  input  logic         err_clr,
  input  logic [W-1:0] crc_q,
  output logic         crc_clr,
  output logic         tx_pec_ins,
  output logic [W-1:0] pec_value,
  output logic         rx_nack,
  output logic         pec_err,
  output logic         crc_bad,
  output logic         dma_pec_req,
  output logic         armed,
  output logic         arm_last
);
  logic         arm_q,  arm_d;
  pec_src_t     src_q,  src_d;
  logic         slot_q, slot_d;
  logic [W-1:0] pecv_q, pecv_d;
  logic         err_q,  err_d;
  logic         bad_q,  bad_d;
  logic         dreq_q, dreq_d;

  logic dma_req, any_req, residue_bad;
  logic tx_fin, tx_take, rx_take, take, err_set;

  assign dma_req     = dma_en & dma_eot;
  assign any_req     = sw_pec_req | dma_req;
  assign residue_bad = |crc_q;

  // byte boundary events; a closing PEC slot takes priority over arming
  assign tx_fin  = pec_en & byte_end & is_tx & slot_q;
  assign tx_take = pec_en & byte_end & is_tx & arm_q & ~slot_q;
  assign rx_take = pec_en & byte_end & ~is_tx & arm_q;
  assign take    = tx_take | rx_take;
  assign err_set = rx_take & residue_bad;

  assign crc_clr = ~pec_en | start_det | tx_fin | rx_take;

  always_comb begin
    arm_d  = arm_q;
    src_d  = src_q;
    slot_d = slot_q;
    pecv_d = pecv_q;
    err_d  = err_q;
    bad_d  = bad_q;
    dreq_d = 1'b0;

    if (!pec_en) begin
      arm_d  = 1'b0;
      slot_d = 1'b0;
      bad_d  = 1'b0;
    end else begin
      // a request in the cycle a byte is consumed only arms the next one
      if (take) arm_d = any_req;
      else      arm_d = arm_q | any_req;

      if (any_req) begin
        src_d.from_dma   = dma_req;
        src_d.final_xfer = dma_req ? dma_last : 1'b1;
      end

      if (tx_fin)       slot_d = 1'b0;
      else if (tx_take) slot_d = 1'b1;

      if (tx_take) pecv_d = crc_q;

      if (start_det)     bad_d = 1'b0;
      else if (arb_lost) bad_d = 1'b1;

      dreq_d = rx_take & src_q.from_dma;
    end

    if (err_set)      err_d = 1'b1;
    else if (err_clr) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      src_q  <= '0;
      slot_q <= 1'b0;
      pecv_q <= '0;
      err_q  <= 1'b0;
      bad_q  <= 1'b0;
      dreq_q <= 1'b0;
    end else begin
      arm_q  <= arm_d;
      src_q  <= src_d;
      slot_q <= slot_d;
      if (tx_take) pecv_q <= pecv_d;
      err_q  <= err_d;
      bad_q  <= bad_d;
      dreq_q <= dreq_d;
    end
  end

  assign rx_nack     = rx_take & (residue_bad | (is_master & src_q.final_xfer));
  assign tx_pec_ins  = slot_q;
  assign pec_value   = pecv_q;
  assign pec_err     = err_q;
  assign crc_bad     = bad_q;
  assign dma_pec_req = dreq_q;
  assign armed       = arm_q;
  assign arm_last    = src_q.final_xfer;
endmodule

// File: rtl/pec_guard.sv
module pec_guard
  import pec_pkg::*;
#(
  parameter int unsigned  W          = PEC_W_DEF,
  parameter logic [W-1:0] POLY       = PEC_POLY_DEF,
  parameter int unsigned  SYNC_STAGE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pec_en,
  input  logic         start_det,
  input  logic         arb_lost,
  input  logic         bit_vld,
  input  logic         bit_val,
  input  logic         byte_end,
  input  logic         is_tx,
  input  logic         is_master,
  input  logic         sw_pec_req,
  input  logic         dma_en,
  input  logic         dma_eot,
  input  logic         dma_last,
  input  logic         err_clr,
  output logic [W-1:0] crc_value,
  output logic [W-1:0] pec_value,
  output logic         tx_pec_ins,
  output logic         rx_nack,
  output logic         pec_err,
  output logic         crc_bad,
  output logic         dma_pec_req
);
  logic rst_sync_n;
  logic crc_clr;
  logic crc_shift;
  logic armed;
  logic arm_last;

  pec_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign crc_shift = pec_en & bit_vld;

  pec_crc_serial #(.W(W), .POLY(POLY)) u_crc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (crc_clr),
    .shift (crc_shift),
    .din   (bit_val),
    .crc   (crc_value)
  );

  pec_seq #(.W(W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .pec_en      (pec_en),
    .start_det   (start_det),
    .arb_lost    (arb_lost),
    .byte_end    (byte_end),
    .is_tx       (is_tx),
    .is_master   (is_master),
    .sw_pec_req  (sw_pec_req),
    .dma_en      (dma_en),
    .dma_eot     (dma_eot),
    .dma_last    (dma_last),
    .err_clr     (err_clr),
    .crc_q       (crc_value),
    .crc_clr     (crc_clr),
    .tx_pec_ins  (tx_pec_ins),
    .pec_value   (pec_value),
    .rx_nack     (rx_nack),
    .pec_err     (pec_err),
    .crc_bad     (crc_bad),
    .dma_pec_req (dma_pec_req),
    .armed       (armed),
    .arm_last    (arm_last)
  );
endmodule

// File: rtl/pec_guard_chk.sv
module pec_guard_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic         pec_en,
  input logic         start_det,
  input logic         byte_end,
  input logic         is_tx,
  input logic         is_master,
  input logic         err_clr,
  input logic         armed,
  input logic         arm_last,
  input logic [W-1:0] crc_value,
  input logic [W-1:0] pec_value,
  input logic         tx_pec_ins,
  input logic         rx_nack,
  input logic         pec_err,
  input logic         crc_bad,
  input logic         dma_pec_req
);
  AST_OFF_CLEARS_CRC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pec_en |=> crc_value == '0); // R2

  AST_START_RESETS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pec_en && start_det) |=> (crc_value == '0 && !crc_bad)); // R3

  AST_PEC_HELD_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_pec_ins && !byte_end && pec_en) |=> $stable(pec_value)); // R4

  AST_MASTER_FINAL_NACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pec_en && byte_end && !is_tx && is_master && armed && arm_last) |-> rx_nack); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pec_err && !err_clr) |=> pec_err); // R8

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(pec_err) |-> $past(rx_nack)); // R8

  AST_DREQ_AFTER_PEC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dma_pec_req |-> $past(byte_end && !is_tx)); // R10

  AST_BAD_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (crc_bad && pec_en && !start_det) |=> crc_bad); // R11

  AST_NACK_WINDOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_nack |-> (byte_end && !is_tx && pec_en && armed)); // R12
endmodule

bind pec_guard pec_guard_chk #(.W(W)) u_chk (.*);

// File: tb/pec_guard_tb.sv
module pec_guard_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n, pec_en, start_det, arb_lost, bit_vld, bit_val, byte_end;
  logic is_tx, is_master, sw_pec_req, dma_en, dma_eot, dma_last, err_clr;
  logic [W-1:0] crc_value, pec_value;
  logic tx_pec_ins, rx_nack, pec_err, crc_bad, dma_pec_req;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk; // 250 MHz

  pec_guard u_dut (
    .clk(clk), .rst_n(rst_n), .pec_en(pec_en), .start_det(start_det),
    .arb_lost(arb_lost), .bit_vld(bit_vld), .bit_val(bit_val),
    .byte_end(byte_end), .is_tx(is_tx), .is_master(is_master),
    .sw_pec_req(sw_pec_req), .dma_en(dma_en), .dma_eot(dma_eot),
    .dma_last(dma_last), .err_clr(err_clr), .crc_value(crc_value),
    .pec_value(pec_value), .tx_pec_ins(tx_pec_ins), .rx_nack(rx_nack),
    .pec_err(pec_err), .crc_bad(crc_bad), .dma_pec_req(dma_pec_req)
  );

  // ---------------- behavioural reference ----------------
  function automatic int crc_bit(input int c, input int b);
    int top;
    top = ((c >> 7) & 1) ^ (b & 1);
    c = (c << 1) & 255;
    if (top != 0) c = c ^ 7;
    return c;
  endfunction

  function automatic int crc_msg(input int msg[$]);
    int c = 0;
    foreach (msg[k])
      for (int i = 7; i >= 0; i--) c = crc_bit(c, (msg[k] >> i) & 1);
    return c;
  endfunction

  int m_s1 = 0, m_s2 = 0;
  int m_crc = 0, m_arm = 0, m_dma = 0, m_last = 0, m_slot = 0;
  int m_pecv = 0, m_err = 0, m_bad = 0, m_dreq = 0;

  always @(posedge clk) begin
    int o_crc, o_arm, o_slot, o_dma;
    int t_tx, t_fin, t_rx, req, dreq_in;
    if (!rst_n || m_s2 == 0) begin
      m_crc = 0; m_arm = 0; m_dma = 0; m_last = 0; m_slot = 0;
      m_pecv = 0; m_err = 0; m_bad = 0; m_dreq = 0;
    end else begin
      o_crc = m_crc; o_arm = m_arm; o_slot = m_slot; o_dma = m_dma;
      dreq_in = dma_en && dma_eot;
      req = sw_pec_req || dreq_in;
      t_fin = pec_en && byte_end && is_tx && o_slot;
      t_tx  = pec_en && byte_end && is_tx && o_arm && !o_slot;
      t_rx  = pec_en && byte_end && !is_tx && o_arm;
      m_dreq = 0;
      if (!pec_en) begin
        m_crc = 0; m_arm = 0; m_slot = 0; m_bad = 0;
      end else begin
        if (start_det || t_fin || t_rx) m_crc = 0;
        else if (bit_vld) m_crc = crc_bit(o_crc, bit_val);
        m_arm = (t_tx || t_rx) ? req : (o_arm || req);
        if (req) begin m_dma = dreq_in; m_last = dreq_in ? dma_last : 1; end
        if (t_fin) m_slot = 0; else if (t_tx) m_slot = 1;
        if (t_tx) m_pecv = o_crc;
        if (start_det) m_bad = 0; else if (arb_lost) m_bad = 1;
        m_dreq = t_rx && o_dma;
      end
      if (t_rx && o_crc != 0) m_err = 1;
      else if (err_clr) m_err = 0;
    end
    if (!rst_n) begin m_s1 = 0; m_s2 = 0; end
    else begin m_s2 = m_s1; m_s1 = 1; end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // compare every output against the reference on every clock
  always @(negedge clk) begin
    int e_nack;
    if (rst_n) begin
      e_nack = (m_s2 && pec_en && byte_end && !is_tx && m_arm &&
                (m_crc != 0 || (is_master && m_last))) ? 1 : 0;
      chk("R1",  "crc_value",   crc_value,   m_crc);
      chk("R4",  "tx_pec_ins",  tx_pec_ins,  m_slot);
      chk("R4",  "pec_value",   pec_value,   m_pecv);
      chk("R6",  "rx_nack",     rx_nack,     e_nack);
      chk("R8",  "pec_err",     pec_err,     m_err);
      chk("R11", "crc_bad",     crc_bad,     m_bad);
      chk("R10", "dma_pec_req", dma_pec_req, m_dreq);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc();
    @(posedge clk); #1;
    sw_pec_req = 0; dma_eot = 0; start_det = 0; arb_lost = 0;
    err_clr = 0; bit_vld = 0; byte_end = 0;
  endtask

  task automatic send_bits(input int b);
    for (int i = 7; i >= 0; i--) begin
      bit_vld = 1; bit_val = (b >> i) & 1; cyc();
    end
  endtask

  task automatic close_byte(output int nk);
    byte_end = 1;
    @(negedge clk); nk = rx_nack;
    cyc();
  endtask

  task automatic begin_msg();
    start_det = 1; cyc();
  endtask

  // receive: two data bytes, arm, then a PEC (optionally corrupted)
  task automatic rx_frame(input int a, input int d, input int flip,
                          input int use_dma, input int last, output int nk);
    int msg[$];
    int p, dummy;
    msg = '{a, d};
    begin_msg();
    send_bits(a); close_byte(dummy);
    chk("R12", "no nack on data byte", dummy, 0);
    send_bits(d); close_byte(dummy);
    if (use_dma) begin dma_eot = 1; dma_last = last; end
    else sw_pec_req = 1;
    cyc();
    p = crc_msg(msg) ^ flip;
    send_bits(p); close_byte(nk);
  endtask

  int nk;
  int vec[$];

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; pec_en = 0; start_det = 0; arb_lost = 0; bit_vld = 0;
    bit_val = 0; byte_end = 0; is_tx = 0; is_master = 0; sw_pec_req = 0;
    dma_en = 0; dma_eot = 0; dma_last = 0; err_clr = 0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    repeat (4) cyc();
    chk("R12", "reset rx_nack", rx_nack, 0);
    chk("R4",  "reset tx_pec_ins", tx_pec_ins, 0);
    chk("R8",  "reset pec_err", pec_err, 0);
    chk("R1",  "reset crc", crc_value, 0);

    // R1 check value
    pec_en = 1; is_tx = 1;
    begin_msg();
    for (int k = 0; k < 9; k++) send_bits(8'h31 + k);
    chk("R1", "crc of 123456789", crc_value, 8'hF4);

    // R4 transmit with software request mid last byte
    begin_msg();
    send_bits(8'hA4); close_byte(nk);
    for (int i = 7; i >= 0; i--) begin
      bit_vld = 1; bit_val = (8'h3C >> i) & 1;
      if (i == 3) sw_pec_req = 1;
      cyc();
    end
    close_byte(nk);
    vec = '{8'hA4, 8'h3C};
    chk("R4", "tx_pec_ins after last byte", tx_pec_ins, 1);
    chk("R4", "pec_value", pec_value, crc_msg(vec));
    send_bits(pec_value); close_byte(nk);
    chk("R4", "slot closed", tx_pec_ins, 0);
    chk("R4", "crc cleared after PEC", crc_value, 0);

    // R5 request in the same cycle as byte_end
    begin_msg();
    send_bits(8'h11);
    sw_pec_req = 1; close_byte(nk);
    chk("R5", "late request not applied", tx_pec_ins, 0);
    send_bits(8'h22); close_byte(nk);
    vec = '{8'h11, 8'h22};
    chk("R5", "applied to next byte", tx_pec_ins, 1);
    chk("R5", "pec of next", pec_value, crc_msg(vec));
    send_bits(pec_value); close_byte(nk);

    // R6 slave receive, good and bad
    is_tx = 0; is_master = 0;
    rx_frame(8'hA5, 8'h77, 0, 0, 0, nk);
    chk("R6", "good PEC acked", nk, 0);
    chk("R8", "no error on good", pec_err, 0);
    chk("R6", "crc cleared", crc_value, 0);
    rx_frame(8'hA5, 8'h77, 1, 0, 0, nk);
    chk("R6", "bad PEC nacked", nk, 1);
    chk("R8", "error set", pec_err, 1);
    cyc(); cyc();
    chk("R8", "error sticky", pec_err, 1);
    err_clr = 1; cyc();
    chk("R8", "error cleared", pec_err, 0);

    // R7 master receive
    is_master = 1;
    rx_frame(8'hB1, 8'h05, 0, 0, 0, nk);
    chk("R7", "master sw PEC forced nack", nk, 1);
    chk("R7", "forced nack no error", pec_err, 0);
    dma_en = 1;
    rx_frame(8'hB1, 8'h06, 0, 1, 0, nk);
    chk("R7", "intermediate DMA PEC acked", nk, 0);
    chk("R10", "dma request pulse", dma_pec_req, 1);
    cyc();
    chk("R10", "dma request one clock", dma_pec_req, 0);
    rx_frame(8'hB1, 8'h07, 0, 1, 1, nk);
    chk("R7", "final DMA PEC nacked", nk, 1);

    // R9 DMA hint ignored without dma_en
    dma_en = 0; is_tx = 1; is_master = 0;
    begin_msg();
    send_bits(8'h40);
    dma_eot = 1; cyc();
    close_byte(nk);
    chk("R9", "eot ignored when dma off", tx_pec_ins, 0);
    dma_en = 1;
    send_bits(8'h41);
    dma_eot = 1; dma_last = 1; cyc();
    close_byte(nk);
    chk("R9", "eot arms when dma on", tx_pec_ins, 1);
    send_bits(pec_value); close_byte(nk);
    dma_en = 0;

    // R11 arbitration loss
    arb_lost = 1; cyc();
    chk("R11", "crc_bad set", crc_bad, 1);
    send_bits(8'h5E);
    chk("R11", "crc_bad held", crc_bad, 1);
    begin_msg();
    chk("R11", "crc_bad cleared by start", crc_bad, 0);

    // R2 disable
    send_bits(8'h9C);
    pec_en = 0; cyc();
    chk("R2", "crc zero when off", crc_value, 0);
    send_bits(8'hFF);
    chk("R2", "bits ignored when off", crc_value, 0);
    sw_pec_req = 1; cyc();
    pec_en = 1;
    send_bits(8'h12); close_byte(nk);
    chk("R2", "request dropped when off", tx_pec_ins, 0);

    repeat (3) cyc();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule